// File: doc/BRIEF.md
# Multi-Mode Interrupt Controller

This block collects interrupt conditions from a vector of sources and turns them into two CPU request lines and one wakeup line. Each source picks its own trigger behaviour from a three-bit code, can be enabled or masked, can be allowed to wake the processor, and is steered to one of the two request lines. Any source can take its input either from its peripheral pin or from a shared single test bit, so software can raise interrupts without any peripheral activity.

Software reaches every control field through a register bus. The bus has an address, a write strobe, write data and combinational read data. Each control register has a pair of write addresses: one ORs the written ones into the register and one clears them. Edge events stay latched in two event registers until software writes a one to the event bit. Level conditions are not stored and follow the selected input directly.

Top module: `irq_mode_ctrl`

## Requirements
- R1: The seven control registers each have a set address and a clear address. The set addresses are trigger bit 0 at 0x40, trigger bit 1 at 0x48, trigger bit 2 at 0x50, input select at 0x58, route at 0x60, wake enable at 0x68 and mask at 0x70, and each clear address is its set address plus 4. A write to a set address ORs in the ones of the data. A write to a clear address removes them. A read of the set address returns the register.
- R2: After a synchronous active-low reset, every register and the test bit read as zero, and req0_o, req1_o and wake_o are low.
- R3: A source's trigger code is {bit2, bit1, bit0} taken from the three trigger registers. Codes 000 and 100 never latch an event and never make the source pending.
- R4: Under codes 001, 011 and 111, a 0-to-1 change of the selected input sets the source's bit in the rise event register (read at 0x78) on the next clock edge. Writing a one to that bit at 0x78 clears it.
- R5: Under codes 010, 011 and 111, a 1-to-0 change of the selected input sets the source's bit in the fall event register (read at 0x7C) on the next clock edge. Writing a one to that bit at 0x7C clears it.
- R6: Code 101 makes a source pending while its selected input is 1, and code 110 makes it pending while the input is 0. Code 111 makes it pending at all times. Level conditions are combinational and are never latched.
- R7: A source drives a request line only while its mask bit is 1. With all mask bits 0, both request lines stay low.
- R8: A pending enabled source with route bit 1 drives req0_o, and one with route bit 0 drives req1_o. Reads at 0x54 and 0x5C return the per-source active vectors for request 0 and request 1.
- R9: With input-select bit 0, a source uses the shared test bit (bit 0 written at 0x80, read back at 0x80) and ignores its peripheral input. With input-select bit 1, it uses the peripheral input.
- R10: wake_o is high exactly when some pending source has its wake-enable bit set, whatever its mask bit.
- R11: An edge event that arrives in the same cycle as a clearing write to its event bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Combinational read data for bus_addr |
| src_in | input | N_SRC | Peripheral interrupt inputs, already synchronous |
| req0_o | output | 1 | CPU request line 0 |
| req1_o | output | 1 | CPU request line 1 |
| wake_o | output | 1 | Wakeup request |

## Verification
A corrupted edge-history or event flop shows on the request line one cycle after the input changes. It appears as a missing request, or as a request under a code that should be silent, and it stays until software clears the event bit. A stuck control bit shows at once on the read-back of its set address and on the routed request or wake output. The bench therefore walks all eight trigger codes on low, middle and top sources. It watches the event registers and the request pins in the cycle right after each input change and after each clearing write.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants and types for the multi-mode interrupt controller.
// Assumes an 8-bit byte address bus; control registers are spaced by 8.
package irq_ctrl_pkg;

    localparam int unsigned BUS_AW    = 8;
    localparam int unsigned NUM_CTRL  = 7;

    typedef logic [BUS_AW-1:0] bus_addr_t;

    // Control register indices; set address = CTRL_BASE + 8*index.
    localparam int unsigned IDX_TRIG0  = 0;
    localparam int unsigned IDX_TRIG1  = 1;
    localparam int unsigned IDX_TRIG2  = 2;
    localparam int unsigned IDX_INSEL  = 3;
    localparam int unsigned IDX_ROUTE  = 4;
    localparam int unsigned IDX_WAKE   = 5;
    localparam int unsigned IDX_MASK   = 6;

    localparam bus_addr_t CTRL_BASE   = 8'h40;
    localparam bus_addr_t ADDR_ACT0   = 8'h54;
    localparam bus_addr_t ADDR_ACT1   = 8'h5C;
    localparam bus_addr_t ADDR_RISE   = 8'h78;
    localparam bus_addr_t ADDR_FALL   = 8'h7C;
    localparam bus_addr_t ADDR_TEST   = 8'h80;

    // Trigger code {bit2, bit1, bit0}.
    typedef enum logic [2:0] {
        TRIG_OFF      = 3'b000,
        TRIG_RISE     = 3'b001,
        TRIG_FALL     = 3'b010,
        TRIG_EDGES    = 3'b011,
        TRIG_OFF_ALT  = 3'b100,
        TRIG_HIGH     = 3'b101,
        TRIG_LOW      = 3'b110,
        TRIG_ALL      = 3'b111
    } trig_mode_e;

    // Returns {rise_en, fall_en, high_en, low_en} for a trigger code.
    function automatic logic [3:0] mode_flags(trig_mode_e m);
        logic [3:0] f;
        case (m)
            TRIG_RISE:  f = 4'b1000;
            TRIG_FALL:  f = 4'b0100;
            TRIG_EDGES: f = 4'b1100;
            TRIG_HIGH:  f = 4'b0010;
            TRIG_LOW:   f = 4'b0001;
            TRIG_ALL:   f = 4'b1111;
            default:    f = 4'b0000;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/irq_setclr_reg.sv
// One control register with a set address and a clear address.
// Assumes at most one bus write per cycle; reset clears every bit.
module irq_setclr_reg
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N        = 32,
    parameter bus_addr_t   SET_ADDR = 8'h40,
    parameter bus_addr_t   CLR_ADDR = 8'h44
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  bus_addr_t     wr_addr_i,
    input  logic [N-1:0]  wr_data_i,
    output logic [N-1:0]  q_o
);

    logic          hit_set;
    logic          hit_clr;
    logic [N-1:0]  reg_q;

    // Decode the two write ports of this register.
    always_comb begin
        hit_set = wr_en_i && (wr_addr_i == SET_ADDR);
        hit_clr = wr_en_i && (wr_addr_i == CLR_ADDR);
    end

    // Apply set or clear of the written ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (hit_set) begin
            reg_q <= reg_q | wr_data_i;
        end else if (hit_clr) begin
            reg_q <= reg_q & ~wr_data_i;
        end
    end

    assign q_o = reg_q;

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == SET_ADDR) |=> ((q_o & $past(wr_data_i)) == $past(wr_data_i))); // R1
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == CLR_ADDR) |=> ((q_o & $past(wr_data_i)) == '0)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (wr_addr_i == SET_ADDR || wr_addr_i == CLR_ADDR)) |=> $stable(q_o)); // R1

endmodule

// File: rtl/irq_mode_decode.sv
// Turns the three per-source trigger bits into four enable flags.
// Purely combinational; codes 000 and 100 yield no flags.
module irq_mode_decode
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] trig0_i,
    input  logic [N-1:0] trig1_i,
    input  logic [N-1:0] trig2_i,
    output logic [N-1:0] rise_en_o,
    output logic [N-1:0] fall_en_o,
    output logic [N-1:0] high_en_o,
    output logic [N-1:0] low_en_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [3:0] flags;
        // Look up the flags for this source's code.
        assign flags        = mode_flags(trig_mode_e'({trig2_i[g], trig1_i[g], trig0_i[g]}));
        assign rise_en_o[g] = flags[3];
        assign fall_en_o[g] = flags[2];
        assign high_en_o[g] = flags[1];
        assign low_en_o[g]  = flags[0];
    end

endmodule

// File: rtl/irq_edge_capture.sv
// Edge event latches: compares each input with last cycle's copy and
// holds rise/fall events until a write-one-to-clear. Inputs must be
// synchronous to clk. A new event beats a clear in the same cycle.
module irq_edge_capture #(
    parameter int unsigned N = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  sig_i,
    input  logic [N-1:0]  rise_en_i,
    input  logic [N-1:0]  fall_en_i,
    input  logic [N-1:0]  rise_clr_i,
    input  logic [N-1:0]  fall_clr_i,
    output logic [N-1:0]  rise_q_o,
    output logic [N-1:0]  fall_q_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rise_q;
    logic [N-1:0] fall_q;
    logic [N-1:0] rise_evt;
    logic [N-1:0] fall_evt;

    // Qualified edge events for this cycle.
    always_comb begin
        rise_evt = sig_i & ~prev_q & rise_en_i;
        fall_evt = ~sig_i & prev_q & fall_en_i;
    end

    // Keep input history and update the event latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            prev_q <= sig_i;
            rise_q <= (rise_q & ~rise_clr_i) | rise_evt;
            fall_q <= (fall_q & ~fall_clr_i) | fall_evt;
        end
    end

    assign rise_q_o = rise_q;
    assign fall_q_o = fall_q;

    AST_NO_RISE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_q_o & ~$past(rise_q_o) & ~$past(rise_en_i)) == '0)); // R3
    AST_NO_FALL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_q_o & ~$past(fall_q_o) & ~$past(fall_en_i)) == '0)); // R3
    AST_RISE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt != '0) |=> ((~rise_q_o & $past(rise_evt)) == '0)); // R11
    AST_FALL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt != '0) |=> ((~fall_q_o & $past(fall_evt)) == '0)); // R11

endmodule

// File: rtl/irq_request_merge.sv
// Builds per-source pending state and reduces it to the two request
// lines and the wakeup line. Purely combinational.
module irq_request_merge #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] sig_i,
    input  logic [N-1:0] rise_q_i,
    input  logic [N-1:0] fall_q_i,
    input  logic [N-1:0] high_en_i,
    input  logic [N-1:0] low_en_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] route_i,
    input  logic [N-1:0] wake_en_i,
    output logic [N-1:0] act0_o,
    output logic [N-1:0] act1_o,
    output logic         req0_o,
    output logic         req1_o,
    output logic         wake_o
);

    logic [N-1:0] pending;
    logic [N-1:0] enabled;

    // Pending = latched edges or live level condition; then mask and route.
    always_comb begin
        pending = rise_q_i | fall_q_i | (high_en_i & sig_i) | (low_en_i & ~sig_i);
        enabled = pending & mask_i;
        act0_o  = enabled & route_i;
        act1_o  = enabled & ~route_i;
        req0_o  = |act0_o;
        req1_o  = |act1_o;
        wake_o  = |(pending & wake_en_i);
    end

endmodule

// File: rtl/irq_mode_ctrl.sv
// Top of the multi-mode interrupt controller: register bus decode,
// set/clear control registers, test-bit input selection, edge capture
// and request merge. Inputs are assumed synchronous to clk.
module irq_mode_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  src_in,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);

    logic [NUM_CTRL-1:0][N_SRC-1:0] ctrl_q;
    logic                           test_q;
    logic [N_SRC-1:0]               sel_sig;
    logic [N_SRC-1:0]               rise_en, fall_en, high_en, low_en;
    logic [N_SRC-1:0]               rise_clr, fall_clr;
    logic [N_SRC-1:0]               rise_q, fall_q;
    logic [N_SRC-1:0]               act0, act1;

    // Control registers, one slice per index.
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        localparam bus_addr_t SA = bus_addr_t'(CTRL_BASE + 8 * g);
        localparam bus_addr_t CA = bus_addr_t'(CTRL_BASE + 8 * g + 4);
        irq_setclr_reg #(.N(N_SRC), .SET_ADDR(SA), .CLR_ADDR(CA)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (bus_we),
            .wr_addr_i (bus_addr),
            .wr_data_i (bus_wdata),
            .q_o       (ctrl_q[g])
        );
    end

    // Shared test bit written through its own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= 1'b0;
        end else if (bus_we && bus_addr == ADDR_TEST) begin
            test_q <= bus_wdata[0];
        end
    end

    // Pick peripheral input or test bit per source.
    always_comb begin
        sel_sig = (ctrl_q[IDX_INSEL] & src_in) | (~ctrl_q[IDX_INSEL] & {N_SRC{test_q}});
    end

    // Write-one-to-clear strobes for the event registers.
    always_comb begin
        rise_clr = (bus_we && bus_addr == ADDR_RISE) ? bus_wdata : '0;
        fall_clr = (bus_we && bus_addr == ADDR_FALL) ? bus_wdata : '0;
    end

    irq_mode_decode #(.N(N_SRC)) u_decode (
        .trig0_i   (ctrl_q[IDX_TRIG0]),
        .trig1_i   (ctrl_q[IDX_TRIG1]),
        .trig2_i   (ctrl_q[IDX_TRIG2]),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .high_en_o (high_en),
        .low_en_o  (low_en)
    );

    irq_edge_capture #(.N(N_SRC)) u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (sel_sig),
        .rise_en_i  (rise_en),
        .fall_en_i  (fall_en),
        .rise_clr_i (rise_clr),
        .fall_clr_i (fall_clr),
        .rise_q_o   (rise_q),
        .fall_q_o   (fall_q)
    );

    irq_request_merge #(.N(N_SRC)) u_merge (
        .sig_i     (sel_sig),
        .rise_q_i  (rise_q),
        .fall_q_i  (fall_q),
        .high_en_i (high_en),
        .low_en_i  (low_en),
        .mask_i    (ctrl_q[IDX_MASK]),
        .route_i   (ctrl_q[IDX_ROUTE]),
        .wake_en_i (ctrl_q[IDX_WAKE]),
        .act0_o    (act0),
        .act1_o    (act1),
        .req0_o    (req0_o),
        .req1_o    (req1_o),
        .wake_o    (wake_o)
    );

    // Read mux: set addresses return registers, shared clear addresses return views.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (bus_addr == bus_addr_t'(CTRL_BASE + 8 * i)) bus_rdata = ctrl_q[i];
        end
        case (bus_addr)
            ADDR_ACT0: bus_rdata = act0;
            ADDR_ACT1: bus_rdata = act1;
            ADDR_RISE: bus_rdata = rise_q;
            ADDR_FALL: bus_rdata = fall_q;
            ADDR_TEST: bus_rdata = {{(N_SRC-1){1'b0}}, test_q};
            default:   ;
        endcase
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[IDX_MASK] == '0) |-> (!req0_o && !req1_o)); // R7
    AST_REQ0_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        req0_o |-> ((ctrl_q[IDX_MASK] & ctrl_q[IDX_ROUTE]) != '0)); // R8
    AST_REQ1_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        req1_o |-> ((ctrl_q[IDX_MASK] & ~ctrl_q[IDX_ROUTE]) != '0)); // R8
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (ctrl_q[IDX_WAKE] != '0)); // R10

endmodule

// File: tb/irq_mode_ctrl_bench.sv
module irq_mode_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        req0, req1, wake;
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_mode_ctrl #(.N_SRC(32)) u_irq_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src),
        .req0_o(req0), .req1_o(req1), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    function automatic bit m_rise(int c); return c == 1 || c == 3 || c == 7; endfunction
    function automatic bit m_fall(int c); return c == 2 || c == 3 || c == 7; endfunction
    function automatic bit m_high(int c); return c == 5 || c == 7; endfunction
    function automatic bit m_low(int c);  return c == 6 || c == 7; endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of every readable address and the outputs.
        for (int a = 8'h40; a <= 8'h80; a += 4) begin
            rd(a[7:0], v);
            chk($sformatf("R2 reset read %h", a), v, 32'h0);
        end
        chk("R2 reset outputs", {29'd0, req0, req1, wake}, 32'h0);

        // R1: set, OR-in, clear and full clear for each control register.
        for (int i = 0; i < 7; i++) begin
            logic [7:0] sa;
            sa = 8'(8'h40 + 8 * i);
            wr(sa, 32'hA5A5_0F0F); rd(sa, v);
            chk($sformatf("R1 set reg%0d", i), v, 32'hA5A5_0F0F);
            wr(sa, 32'h1000_0000); rd(sa, v);
            chk($sformatf("R1 or reg%0d", i), v, 32'hB5A5_0F0F);
            wr(8'(sa + 4), 32'h0000_0F00); rd(sa, v);
            chk($sformatf("R1 clear reg%0d", i), v, 32'hB5A5_000F);
            wr(8'(sa + 4), 32'hFFFF_FFFF); rd(sa, v);
            chk($sformatf("R1 clear all reg%0d", i), v, 32'h0);
        end

        // R3..R6, R8: all eight codes on three sources, routed to request 0.
        for (int j = 0; j < 3; j++) begin
            int k;
            k = (j == 0) ? 0 : (j == 1) ? 13 : 31;
            wr(8'h70, 32'h1 << k); wr(8'h60, 32'h1 << k); wr(8'h58, 32'h1 << k);
            for (int c = 0; c < 8; c++) begin
                wr(8'h44, 32'h1 << k); wr(8'h4C, 32'h1 << k); wr(8'h54, 32'h1 << k);
                if (c[0]) wr(8'h40, 32'h1 << k);
                if (c[1]) wr(8'h48, 32'h1 << k);
                if (c[2]) wr(8'h50, 32'h1 << k);
                wr(8'h78, 32'hFFFF_FFFF); wr(8'h7C, 32'hFFFF_FFFF);
                @(negedge clk); src[k] = 1'b1;
                @(negedge clk); #1;
                chk($sformatf("R6 R3 req0 after rise src%0d code%0d", k, c), {31'd0, req0},
                    {31'd0, m_rise(c) | m_high(c)});
                rd(8'h78, v);
                chk($sformatf("R4 rise latch src%0d code%0d", k, c), v, m_rise(c) ? (32'h1 << k) : 32'h0);
                rd(8'h5C, v);
                chk($sformatf("R8 req1 view src%0d code%0d", k, c), v, 32'h0);
                wr(8'h78, 32'h1 << k); #1;
                chk($sformatf("R6 level only src%0d code%0d", k, c), {31'd0, req0}, {31'd0, m_high(c)});
                @(negedge clk); src[k] = 1'b0;
                @(negedge clk); #1;
                chk($sformatf("R6 R3 req0 after fall src%0d code%0d", k, c), {31'd0, req0},
                    {31'd0, m_fall(c) | m_low(c)});
                rd(8'h7C, v);
                chk($sformatf("R5 fall latch src%0d code%0d", k, c), v, m_fall(c) ? (32'h1 << k) : 32'h0);
                wr(8'h7C, 32'h1 << k); #1;
                chk($sformatf("R5 fall cleared src%0d code%0d", k, c), {31'd0, req0}, {31'd0, m_low(c)});
            end
            wr(8'h44, 32'h1 << k); wr(8'h4C, 32'h1 << k); wr(8'h54, 32'h1 << k);
            wr(8'h74, 32'h1 << k); wr(8'h64, 32'h1 << k); wr(8'h5C, 32'h1 << k);
        end

        // R8, R7, R10: routing, masking, wake on source 4 in high-level mode.
        wr(8'h50, 32'h10); wr(8'h40, 32'h10); wr(8'h58, 32'h10); wr(8'h70, 32'h10);
        @(negedge clk); src[4] = 1'b1; #1;
        chk("R8 route0 to req1", {30'd0, req0, req1}, 32'h1);
        rd(8'h5C, v); chk("R8 req1 view", v, 32'h10);
        rd(8'h54, v); chk("R8 req0 view empty", v, 32'h0);
        wr(8'h60, 32'h10); #1;
        chk("R8 route1 to req0", {30'd0, req0, req1}, 32'h2);
        rd(8'h54, v); chk("R8 req0 view", v, 32'h10);
        wr(8'h74, 32'h10); #1;
        chk("R7 masked quiet", {30'd0, req0, req1}, 32'h0);
        rd(8'h54, v); chk("R7 masked view", v, 32'h0);
        chk("R10 wake off", {31'd0, wake}, 32'h0);
        wr(8'h68, 32'h10); #1;
        chk("R10 wake while masked", {31'd0, wake}, 32'h1);
        @(negedge clk); src[4] = 1'b0; #1;
        chk("R10 wake follows pending", {31'd0, wake}, 32'h0);
        @(negedge clk); src[4] = 1'b1;
        wr(8'h6C, 32'h10); #1;
        chk("R10 wake disabled", {31'd0, wake}, 32'h0);
        wr(8'h54, 32'h10); wr(8'h44, 32'h10); wr(8'h64, 32'h10); wr(8'h5C, 32'h10);
        @(negedge clk); src[4] = 1'b0;

        // R9: test bit versus peripheral input on source 7.
        wr(8'h50, 32'h80); wr(8'h40, 32'h80); wr(8'h70, 32'h80); wr(8'h60, 32'h80);
        @(negedge clk); src[7] = 1'b1; #1;
        chk("R9 peripheral ignored", {31'd0, req0}, 32'h0);
        wr(8'h80, 32'h1); #1;
        chk("R9 test bit drives", {31'd0, req0}, 32'h1);
        rd(8'h80, v); chk("R9 test bit read", v, 32'h1);
        wr(8'h80, 32'h0); #1;
        chk("R9 test bit low", {31'd0, req0}, 32'h0);
        wr(8'h58, 32'h80); #1;
        chk("R9 peripheral selected", {31'd0, req0}, 32'h1);
        wr(8'h54, 32'h80); wr(8'h44, 32'h80); wr(8'h5C, 32'h80);
        @(negedge clk); src[7] = 1'b0;

        // R11: rising event and clearing write in the same cycle on source 2.
        wr(8'h40, 32'h4); wr(8'h58, 32'h4); wr(8'h70, 32'h4); wr(8'h60, 32'h4);
        @(negedge clk); we = 1'b1; addr = 8'h78; wdata = 32'h4; src[2] = 1'b1;
        @(negedge clk); we = 1'b0; addr = 8'h00; wdata = '0; #1;
        chk("R11 event kept req0", {31'd0, req0}, 32'h1);
        rd(8'h78, v); chk("R11 event kept latch", v, 32'h4);
        wr(8'h78, 32'h4); rd(8'h78, v);
        chk("R4 later clear works", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule